// File: doc/BRIEF.md
# Parallel Multi-Lane LED Strip Bit Transmitter

This block drives up to 32 serial LED strings of the 800 kHz single-wire type at the same time, one output lane per string. All lanes share one bit timebase. The upstream source does not send one serial stream per string. It sends bit-plane words, and each word holds the current bit for every lane. For each bit slot the block takes one word and shapes every enabled lane with three fixed compare points. At the start of the slot all enabled lanes rise. At the first compare point the lanes whose bit is 0 fall. At the second compare point all lanes are low.

A frame begins with a one-cycle start pulse. The pulse captures the lane-enable mask and the LED count, and the frame then uses 24 words per LED. One all-low slot comes before the data and one comes after it, so the first and last data pulses are never clipped. After the trailing slot every lane stays low for a latch guard time. At the end of the guard time a one-cycle done pulse is raised and busy drops.

Words arrive on a valid/ready stream. The block raises ready for exactly one cycle, the last cycle of a slot, and only while words of the frame are still owed. A word transfers on a cycle where valid and ready are both high. The source may hold valid high for as long as it likes, and holding valid costs nothing outside those cycles. Ready never depends on valid. If valid is low when ready is high, the frame is cut short as an underrun.

Top module: `ws_lane_tx`

## Requirements
- R1: A bit slot lasts SLOT_CYC clock cycles (default 60). Within a frame, consecutive rising edges on any lane are exactly SLOT_CYC cycles apart.
- R2: In a data slot, an enabled lane whose bit in the slot's word is 1 is high for T1_CYC cycles (default 31) and then low for the rest of the slot.
- R3: In a data slot, an enabled lane whose bit in the slot's word is 0 is high for T0_CYC cycles (default 12) and then low for the rest of the slot.
- R4: A frame consumes exactly 24 × led_count_i words. Bit i of a word shapes lane i. word_ready_o is high only in the last cycle of a slot while the block is busy, and a word transfers on a cycle where word_valid_i and word_ready_o are both high.
- R5: A lane whose bit in the lane-enable mask captured at start is 0 stays low for the whole frame.
- R6: After reset all lanes are low and busy_o, done_o, word_ready_o and underrun_o are 0. Each frame begins with one full all-low slot, so the first rising edge appears SLOT_CYC+1 cycles after the start cycle's following cycle. Each frame also ends with one full all-low slot.
- R7: After the trailing slot all lanes stay low for GUARD_CYC cycles (default 2640). done_o then pulses high for one cycle, and busy_o falls in that same cycle.
- R8: A start pulse while busy_o is high is ignored: the mask, the LED count and the ongoing waveform are unchanged.
- R9: If word_valid_i is low in a cycle where word_ready_o is high, underrun_o rises, all lanes stay low, the guard time runs and done_o pulses. underrun_o holds until the next accepted start.
- R10: A frame with led_count_i = 0 requests no words, produces no pulse, and raises done_o after the leading slot, the trailing slot and the guard time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock (48 MHz in the default configuration) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame; ignored while busy |
| lane_en_i | input | LANES | Lane-enable mask, captured at start |
| led_count_i | input | LED_W | LEDs per string, captured at start |
| word_i | input | LANES | Bit-plane word, bit i for lane i |
| word_valid_i | input | 1 | Source has a word on word_i |
| word_ready_o | output | 1 | Block takes a word this cycle if valid |
| lane_o | output | LANES | Shaped serial output, one per string |
| busy_o | output | 1 | Frame in progress, including guard time |
| done_o | output | 1 | One-cycle pulse at the end of the guard time |
| underrun_o | output | 1 | Last frame ended because a word was missing |

## Verification
The embedded properties assume that rst_n is held low across at least one rising edge, that inputs carry no unknown values, and that the timing parameters obey T0_CYC < T1_CYC < SLOT_CYC. They also assume that the mask and the LED count matter only in the cycle where start is taken. The stimulus drives every input one time unit after a rising edge, so nothing changes at the active edge. It keeps start high for exactly one cycle, and it keeps valid at a defined 0 or 1 from reset onward. It changes the enable mask and the count only at start, except in the one case that deliberately pokes them while the block is busy. Underrun is provoked only by dropping valid, never by driving unknown data.

// File: rtl/ws_lane_pkg.sv
package ws_lane_pkg;
  // Frame phases of the transmitter
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_TRAIL,
    ST_GUARD
  } phase_e;

  localparam int BITS_PER_LED = 24;
endpackage

// File: rtl/ws_slot_timer.sv
module ws_slot_timer #(
  parameter int SLOT_CYC = 60,
  parameter int CNT_W    = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SLOT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == LAST_C);

  // slot position never leaves its range
  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);

  // an idle timer restarts from position zero
  assert_slot_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/ws_lane_shaper.sv
module ws_lane_shaper #(
  parameter int LANES  = 32,
  parameter int CNT_W  = 6,
  parameter int T0_CYC = 12,
  parameter int T1_CYC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LANES-1:0] word_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] lane_o
);
  localparam logic [CNT_W-1:0] T0_C = CNT_W'(T0_CYC);
  localparam logic [CNT_W-1:0] T1_C = CNT_W'(T1_CYC);

  logic             early_w;
  logic             mid_w;
  logic [LANES-1:0] lane_d;
  logic [LANES-1:0] lane_q;

  assign early_w = cnt_i < T0_C;
  assign mid_w   = cnt_i < T1_C;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_d[g] = drive_i & mask_i[g] & (early_w | (mid_w & word_i[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assign lane_o = lane_q;

  // disabled lanes never show a pulse
  assert_masked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_q & ~mask_i) == '0);

  // outside data slots the following cycle is all low
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> lane_q == '0);
endmodule

// File: rtl/ws_frame_ctrl.sv
module ws_frame_ctrl
  import ws_lane_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int LED_W     = 8,
  parameter int GUARD_CYC = 2640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LED_W-1:0] leds_i,
  input  logic [LANES-1:0] word_i,
  input  logic             word_valid_i,
  input  logic             slot_last_i,
  output logic             word_ready_o,
  output phase_e           phase_o,
  output logic [LANES-1:0] word_o,
  output logic [LANES-1:0] mask_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);
  localparam int WL_W = LED_W + 5;
  localparam int GC_W = (GUARD_CYC > 2) ? $clog2(GUARD_CYC) : 2;
  localparam logic [GC_W-1:0] GUARD_LAST = GC_W'(GUARD_CYC - 1);

  phase_e           phase_q;
  logic [WL_W-1:0]  left_q;
  logic [LANES-1:0] word_q;
  logic [LANES-1:0] mask_q;
  logic [GC_W-1:0]  gcnt_q;
  logic             done_q;
  logic             under_q;
  logic             take_slot;
  logic [WL_W-1:0]  words_total;

  assign take_slot    = ((phase_q == ST_LEAD) || (phase_q == ST_DATA)) && slot_last_i;
  assign word_ready_o = take_slot && (left_q != '0);
  // 24 words per LED: 16x + 8x
  assign words_total  = (WL_W'(leds_i) << 4) + (WL_W'(leds_i) << 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      left_q  <= '0;
      word_q  <= '0;
      mask_q  <= '0;
      gcnt_q  <= '0;
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q  <= mask_i;
            left_q  <= words_total;
            under_q <= 1'b0;
            phase_q <= ST_LEAD;
          end
        end
        ST_LEAD, ST_DATA: begin
          if (take_slot) begin
            if (left_q == '0) begin
              phase_q <= ST_TRAIL;
            end else if (word_valid_i) begin
              word_q  <= word_i;
              left_q  <= left_q - 1'b1;
              phase_q <= ST_DATA;
            end else begin
              under_q <= 1'b1;
              gcnt_q  <= '0;
              phase_q <= ST_GUARD;
            end
          end
        end
        ST_TRAIL: begin
          if (slot_last_i) begin
            gcnt_q  <= '0;
            phase_q <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (gcnt_q == GUARD_LAST) begin
            done_q  <= 1'b1;
            phase_q <= ST_IDLE;
          end else begin
            gcnt_q <= gcnt_q + 1'b1;
          end
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign word_o     = word_q;
  assign mask_o     = mask_q;
  assign busy_o     = phase_q != ST_IDLE;
  assign done_o     = done_q;
  assign underrun_o = under_q;

  // words are only requested at a slot end of a running frame
  assert_ready_slot_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> (slot_last_i && busy_o));

  // done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // the frame only ends through the done pulse
  assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q);

  // a missing word sends the frame straight to the guard phase
  assert_underrun_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_q) |-> phase_q == ST_GUARD);

  // a start while busy leaves the captured mask alone
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_q) |=> mask_q == $past(mask_q));
endmodule

// File: rtl/ws_lane_tx.sv
module ws_lane_tx
  import ws_lane_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int LED_W     = 8,
  parameter int SLOT_CYC  = 60,
  parameter int T0_CYC    = 12,
  parameter int T1_CYC    = 31,
  parameter int GUARD_CYC = 2640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [LED_W-1:0] led_count_i,
  input  logic [LANES-1:0] word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  output logic [LANES-1:0] lane_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);
  localparam int CNT_W = $clog2(SLOT_CYC);

  phase_e           phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic             last_w;
  logic             run_w;
  logic [LANES-1:0] word_w;
  logic [LANES-1:0] mask_w;

  assign run_w = (phase_w == ST_LEAD) || (phase_w == ST_DATA) || (phase_w == ST_TRAIL);

  ws_slot_timer #(
    .SLOT_CYC(SLOT_CYC),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run_w),
    .cnt_o (cnt_w),
    .last_o(last_w)
  );

  ws_frame_ctrl #(
    .LANES    (LANES),
    .LED_W    (LED_W),
    .GUARD_CYC(GUARD_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mask_i      (lane_en_i),
    .leds_i      (led_count_i),
    .word_i      (word_i),
    .word_valid_i(word_valid_i),
    .slot_last_i (last_w),
    .word_ready_o(word_ready_o),
    .phase_o     (phase_w),
    .word_o      (word_w),
    .mask_o      (mask_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .underrun_o  (underrun_o)
  );

  ws_lane_shaper #(
    .LANES (LANES),
    .CNT_W (CNT_W),
    .T0_CYC(T0_CYC),
    .T1_CYC(T1_CYC)
  ) u_shaper (
    .clk    (clk),
    .rst_n  (rst_n),
    .drive_i(phase_w == ST_DATA),
    .cnt_i  (cnt_w),
    .word_i (word_w),
    .mask_i (mask_w),
    .lane_o (lane_o)
  );

  // no lane is high in the cycle that reports the end of a frame
  assert_done_lanes_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> lane_o == '0);
endmodule

// File: tb/ws_lane_tx_tb.sv
module ws_lane_tx_tb;
  localparam int LANES = 32;
  localparam int LED_W = 8;
  localparam int SLOT  = 60;
  localparam int T0    = 12;
  localparam int T1    = 31;
  localparam int GUARD = 2640;

  typedef struct packed {
    logic [31:0] mask;
    logic [7:0]  leds;
    logic [31:0] seed;
    logic        poke;
  } vec_t;

  // table of frames: mask, LED count, data seed, mid-frame start poke
  localparam vec_t VECS [5] = '{
    '{32'hFFFF_FFFF, 8'd1, 32'h1234_5678, 1'b0},
    '{32'h0000_F00F, 8'd2, 32'hCAFE_0001, 1'b0},
    '{32'hAAAA_5555, 8'd1, 32'h0BAD_F00D, 1'b1},
    '{32'h0000_0001, 8'd3, 32'h1357_9BDF, 1'b0},
    '{32'hFFFF_FFFF, 8'd0, 32'h0000_0000, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [LANES-1:0] en;
  logic [LED_W-1:0] leds;
  logic [LANES-1:0] data;
  logic             valid;
  logic             ready;
  logic [LANES-1:0] lanes;
  logic             busy;
  logic             done;
  logic             under;

  always #2 clk = ~clk;

  ws_lane_tx #(
    .LANES(LANES), .LED_W(LED_W), .SLOT_CYC(SLOT), .T0_CYC(T0),
    .T1_CYC(T1), .GUARD_CYC(GUARD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_en_i(en),
    .led_count_i(leds), .word_i(data), .word_valid_i(valid),
    .word_ready_o(ready), .lane_o(lanes), .busy_o(busy), .done_o(done),
    .underrun_o(under)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [31:0] gen(input logic [31:0] s, input int k);
    logic [31:0] x;
    x = s ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic        mon_clear = 1'b1;
  logic [31:0] cur_mask  = '0;
  logic [31:0] cur_seed  = '0;
  int t_now, words_taken, e0, e1, mask_err, per_err, first_rise;
  int lowrun, low_before_done, done_t;
  bit done_seen;
  int hi_len [LANES];
  int pidx [LANES];
  int last_rise [LANES];

  always @(negedge clk) begin
    if (mon_clear) begin
      t_now = -1; words_taken = 0; e0 = 0; e1 = 0; mask_err = 0; per_err = 0;
      first_rise = -1; lowrun = 0; low_before_done = -1; done_t = -1;
      done_seen = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        hi_len[i] = 0; pidx[i] = 0; last_rise[i] = -1;
      end
    end else begin
      bit any;
      t_now++;
      if (done && !done_seen) begin
        done_seen = 1'b1; done_t = t_now; low_before_done = lowrun;
      end
      if (valid && ready) words_taken++;
      any = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        if (lanes[i]) begin
          any = 1'b1;
          if (!cur_mask[i]) mask_err++;
          if (hi_len[i] == 0) begin
            if (first_rise < 0) first_rise = t_now;
            if (last_rise[i] >= 0 && (t_now - last_rise[i]) != SLOT) per_err++;
            last_rise[i] = t_now;
          end
          hi_len[i]++;
        end else if (hi_len[i] != 0) begin
          logic [31:0] w;
          w = gen(cur_seed, pidx[i]);
          if (w[i]) begin if (hi_len[i] != T1) e1++; end
          else      begin if (hi_len[i] != T0) e0++; end
          pidx[i]++;
          hi_len[i] = 0;
        end
      end
      lowrun = any ? 0 : lowrun + 1;
    end
  end

  // ---------------- frame driver and checks ----------------
  task automatic run_frame(input logic [31:0] m, input int n, input logic [31:0] s,
                           input bit poke, input int limit);
    int k, to, words_exp, w_last, lr_exp, done_exp, pulses;
    bit hs, complete;
    cur_mask = m; cur_seed = s;
    @(posedge clk); #1;
    mon_clear = 1'b1; en = m; leds = LED_W'(n); k = 0;
    valid = (limit > 0); data = gen(s, 0);
    @(posedge clk); #1;
    mon_clear = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    to = 0;
    while (!done_seen && to < 20000) begin
      @(negedge clk);
      hs = valid && ready;
      @(posedge clk); #1;
      if (hs) begin
        k++;
        if (k >= limit) valid = 1'b0;
        else            data  = gen(s, k);
      end
      if (poke && to == 100) begin start = 1'b1; en = ~m; leds = 8'd5; end
      if (poke && to == 101) begin start = 1'b0; en = m;  leds = LED_W'(n); end
      to++;
    end
    valid = 1'b0; start = 1'b0;
    @(negedge clk);

    complete  = limit >= 24 * n;
    words_exp = complete ? 24 * n : limit;
    done_exp  = complete ? 1 + SLOT * (2 + words_exp) + GUARD
                         : 1 + SLOT * (1 + words_exp) + GUARD;
    pulses = 0;
    for (int i = 0; i < LANES; i++) pulses += pidx[i];

    chk(done_seen, "R7 done pulse seen", int'(done_seen), 1);
    chk(done_t == done_exp, "R7 done cycle", done_t, done_exp);
    chk(!busy, "R7 busy low after done", int'(busy), 0);
    chk(words_taken == words_exp, poke ? "R8 words taken despite busy start" : "R4 words taken",
        words_taken, words_exp);
    chk(pulses == words_exp * $countones(m), "R4 pulse count", pulses, words_exp * $countones(m));
    chk(e1 == 0, "R2 one-bit width errors", e1, 0);
    chk(e0 == 0, "R3 zero-bit width errors", e0, 0);
    chk(mask_err == 0, poke ? "R8 mask kept while busy" : "R5 masked lane activity", mask_err, 0);
    chk(per_err == 0, "R1 slot period errors", per_err, 0);
    chk(int'(under) == int'(!complete), "R9 underrun flag", int'(under), int'(!complete));
    if (words_exp > 0 && m != 0) begin
      w_last = ((gen(s, words_exp - 1) & m) != 0) ? T1 : T0;
      lr_exp = (SLOT - 1 - w_last) + (complete ? SLOT : 0) + GUARD;
      chk(first_rise == SLOT + 2, "R6 leading zero slot", first_rise, SLOT + 2);
      chk(low_before_done == lr_exp, complete ? "R6 R7 trailing low run" : "R9 low after underrun",
          low_before_done, lr_exp);
    end else begin
      chk(first_rise < 0, "R10 no pulse in empty frame", first_rise, -1);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; start = 1'b0; en = '0; leds = '0; data = '0; valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lanes == '0, "R6 lanes low in reset", int'(lanes), 0);
    chk(!busy && !done, "R6 busy/done low in reset", int'(busy) + int'(done), 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(lanes == '0, "R6 lanes low after reset", int'(lanes), 0);
    chk(!ready, "R6 ready low after reset", int'(ready), 0);
    chk(!under && !busy, "R6 underrun/busy low after reset", int'(under) + int'(busy), 0);

    // table-driven frames
    for (int v = 0; v < 5; v++) begin
      run_frame(VECS[v].mask, int'(VECS[v].leds), VECS[v].seed, VECS[v].poke,
                24 * int'(VECS[v].leds));
    end

    // directed: source runs dry after five words (R9)
    run_frame(32'hFFFF_FFFF, 2, 32'h0F0F_1234, 1'b0, 5);
    // directed: source never supplies a word (R9)
    run_frame(32'h00FF_00FF, 1, 32'h2222_0000, 1'b0, 0);
    // directed: clean frame after underrun clears the flag (R9)
    run_frame(32'h8000_0001, 1, 32'h0000_0077, 1'b0, 24);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule